// File: doc/BRIEF.md
# Bridge Path Takeover Controller

This block sits between a command queue, a return-data queue and a physical bus bridge. Normally all traffic flows straight through it. A bridge sequencer pulls commands from the command queue and drives the outbound address/data and command lines. Words arriving from the bridge are written into the return queue. A small embedded controller, attached through a register port, can take over either direction on its own.

Two mode bits select the takeover. In outbound takeover the sequencer is cut off. The controller then peeks at the head of the command queue, dequeues it with a register write, and issues bridge beats by writing data to one of four issue addresses. The low two address bits of that write become the bridge command code. In inbound takeover, bridge words go into a two-entry holding buffer, because the controller cannot accept a word on every cycle. The controller reads and pops that buffer, and it may push words into the return queue itself. A status word gathers the queue fill levels, the buffer level, both mode bits and the sequencer-busy flag. Reads of the status word, the command head and the buffer head never alter any state. A mode change waits until the affected path is idle.

Top module: `bridge_takeover`

## Requirements
- R1: After reset both mode bits are 0, the holding buffer is empty and the block is in pass-through in both directions.
- R2: In outbound pass-through: cmdQDeq equals seqDeq, seqValid equals cmdQValid, and brAd, brCmd and brAdValid equal seqAd, seqCmd and seqAdValid. In inbound pass-through: retData equals brIn, retEnq equals brInValid AND retReady, and brInReady equals retReady. seqData always equals cmdQData.
- R3: While a direction is in pass-through, controller writes to addresses 4 to 10 have no effect on that direction's outputs.
- R4: A write to address 0 sets the requested outbound mode from ctlWData bit 0 and the requested inbound mode from bit 1. The effective outbound bit follows its request at the first clock edge, counting the writing edge itself, at which seqBusy is low. The effective inbound bit follows its request at the first such edge at which brInValid is low and the holding buffer is empty.
- R5: In outbound takeover, seqValid is 0 and the sequencer inputs are ignored. A write to address 4, 5, 6 or 7 drives, in the same cycle, brAdValid=1, brAd=ctlWData and brCmd=ctlAddr[1:0]. In every other cycle of this mode, brAdValid, brAd and brCmd are 0.
- R6: In outbound takeover, a write to address 8 raises cmdQDeq in the same cycle only if cmdQValid is high. Otherwise cmdQDeq is 0.
- R7: In inbound takeover, each bridge word offered while the buffer holds fewer than 2 words is stored. brInReady is high exactly when fewer than 2 words are held. No bridge word reaches the return queue, and words leave the buffer in arrival order.
- R8: Reading address 2 returns the oldest buffered word, or 0 if the buffer is empty. In inbound takeover a write to address 9 removes the oldest word. Such a write to an empty buffer changes nothing.
- R9: In inbound takeover, a write to address 10 drives retData=ctlWData and retEnq=retReady in the same cycle. In every other cycle of this mode, retData and retEnq are 0.
- R10: ctlRdData is combinational on ctlAddr, and reads have no side effects. Address 0 returns a status word: bits 4:0 cmdQCount, 9:5 retCount, 11:10 buffer level, 12 outbound mode, 13 inbound mode, 14 seqBusy, and zeros above. Address 1 returns cmdQData. Every other address except 2 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdQData | input | 32 | Head word of the command queue |
| cmdQValid | input | 1 | Command queue not empty |
| cmdQDeq | output | 1 | Dequeue strobe to the command queue |
| cmdQCount | input | 5 | Command queue fill level |
| seqData | output | 32 | Command word presented to the sequencer |
| seqValid | output | 1 | Command available to the sequencer |
| seqDeq | input | 1 | Sequencer dequeue request |
| seqAd | input | 32 | Sequencer outbound address/data |
| seqCmd | input | 2 | Sequencer outbound command code |
| seqAdValid | input | 1 | Sequencer outbound beat valid |
| seqBusy | input | 1 | Sequencer is in the middle of a command |
| brAd | output | 32 | Outbound address/data to the bridge |
| brCmd | output | 2 | Outbound command code to the bridge |
| brAdValid | output | 1 | Outbound beat valid |
| brIn | input | 32 | Inbound word from the bridge |
| brInValid | input | 1 | Inbound word valid |
| brInReady | output | 1 | Inbound word accepted |
| retData | output | 32 | Word written to the return queue |
| retEnq | output | 1 | Enqueue strobe to the return queue |
| retReady | input | 1 | Return queue can accept a word |
| retCount | input | 5 | Return queue fill level |
| ctlAddr | input | 4 | Controller register address |
| ctlWr | input | 1 | Controller write strobe |
| ctlWData | input | 32 | Controller write data |
| ctlRdData | output | 32 | Controller read data |

## Verification
A behavioural model with a queue for the holding buffer is compared against every output on every cycle. It is driven first with random pass-through traffic, including stray controller writes, which shows whether takeover strobes leak while a path is not owned. Scripted runs hold seqBusy or brInValid, or leave words in the buffer, while a mode change is requested. These separate a deferred switch from an immediate one. A four-word inbound burst against the two-entry buffer shows whether back-pressure and ordering hold at the full boundary. A long mixed phase with random mode writes covers the interaction of switching, popping, pushing and status reads.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int CTL_ADDR_W = 4;
  localparam int CMD_W      = 2;

  // read addresses
  localparam logic [CTL_ADDR_W-1:0] RD_STATUS   = 4'd0;
  localparam logic [CTL_ADDR_W-1:0] RD_CMD_HEAD = 4'd1;
  localparam logic [CTL_ADDR_W-1:0] RD_BUF_HEAD = 4'd2;
  // write addresses; 4..7 issue a bridge beat, low bits give the command
  localparam logic [CTL_ADDR_W-1:0] WR_MODE     = 4'd0;
  localparam logic [CTL_ADDR_W-3:0] WR_ISSUE_PG = 2'd1;
  localparam logic [CTL_ADDR_W-1:0] WR_CMD_POP  = 4'd8;
  localparam logic [CTL_ADDR_W-1:0] WR_BUF_POP  = 4'd9;
  localparam logic [CTL_ADDR_W-1:0] WR_RET_PUSH = 4'd10;

  typedef struct packed {
    logic outOwn;
    logic inOwn;
    logic issue;
    logic cmdPop;
    logic bufPop;
    logic retPush;
  } strobes_t;
endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctlWr,
  input  logic [CTL_ADDR_W-1:0] ctlAddr,
  input  logic [1:0]            modeBits,
  input  logic                  seqBusy,
  input  logic                  brInValid,
  input  logic                  bufEmpty,
  output strobes_t              strb
);
  logic outReqQ, inReqQ, outOwnQ, inOwnQ;
  logic modeWr, outReqD, inReqD, outIdle, inIdle;

  assign modeWr  = ctlWr && (ctlAddr == WR_MODE);
  assign outReqD = modeWr ? modeBits[0] : outReqQ;
  assign inReqD  = modeWr ? modeBits[1] : inReqQ;
  assign outIdle = !seqBusy;
  assign inIdle  = !brInValid && bufEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReqQ <= 1'b0;
      inReqQ  <= 1'b0;
      outOwnQ <= 1'b0;
      inOwnQ  <= 1'b0;
    end else begin
      outReqQ <= outReqD;
      inReqQ  <= inReqD;
      if (outIdle) outOwnQ <= outReqD;
      if (inIdle)  inOwnQ  <= inReqD;
    end
  end

  always_comb begin
    strb.outOwn  = outOwnQ;
    strb.inOwn   = inOwnQ;
    strb.issue   = outOwnQ && ctlWr && (ctlAddr[CTL_ADDR_W-1:2] == WR_ISSUE_PG);
    strb.cmdPop  = outOwnQ && ctlWr && (ctlAddr == WR_CMD_POP);
    strb.bufPop  = inOwnQ  && ctlWr && (ctlAddr == WR_BUF_POP);
    strb.retPush = inOwnQ  && ctlWr && (ctlAddr == WR_RET_PUSH);
  end

  // a switch of the outbound owner only happens on an idle sequencer
  assert_out_switch_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outOwnQ != $past(outOwnQ)) |-> !$past(seqBusy));
  // a switch of the inbound owner only happens with no word offered and an empty buffer
  assert_in_switch_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inOwnQ != $past(inOwnQ)) |-> (!$past(brInValid) && $past(bufEmpty)));
endmodule

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 5,
  parameter int BUF_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  logic [CTL_ADDR_W-1:0] ctlAddr,
  input  logic [DATA_W-1:0]     ctlWData,
  output logic [DATA_W-1:0]     ctlRdData,
  input  logic [DATA_W-1:0]     cmdQData,
  input  logic                  cmdQValid,
  output logic                  cmdQDeq,
  input  logic [CNT_W-1:0]      cmdQCount,
  output logic [DATA_W-1:0]     seqData,
  output logic                  seqValid,
  input  logic                  seqDeq,
  input  logic [DATA_W-1:0]     seqAd,
  input  logic [CMD_W-1:0]      seqCmd,
  input  logic                  seqAdValid,
  input  logic                  seqBusy,
  output logic [DATA_W-1:0]     brAd,
  output logic [CMD_W-1:0]      brCmd,
  output logic                  brAdValid,
  input  logic [DATA_W-1:0]     brIn,
  input  logic                  brInValid,
  output logic                  brInReady,
  output logic [DATA_W-1:0]     retData,
  output logic                  retEnq,
  input  logic                  retReady,
  input  logic [CNT_W-1:0]      retCount,
  output logic                  bufEmpty
);
  localparam int PTR_W  = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int BCNT_W = $clog2(BUF_DEPTH + 1);
  localparam int ST_W   = 2 * CNT_W + BCNT_W + 3;
  localparam logic [BCNT_W-1:0] FULL_LVL = BCNT_W'(BUF_DEPTH);
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(BUF_DEPTH - 1);

  logic [DATA_W-1:0] bufMem [BUF_DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [BCNT_W-1:0] bufCount;
  logic bufFull, push, pop;
  logic [ST_W-1:0] statusWord;

  // outbound direction
  assign seqData   = cmdQData;
  assign seqValid  = strb.outOwn ? 1'b0 : cmdQValid;
  assign cmdQDeq   = strb.outOwn ? (strb.cmdPop && cmdQValid) : seqDeq;
  assign brAd      = strb.outOwn ? (strb.issue ? ctlWData : '0) : seqAd;
  assign brCmd     = strb.outOwn ? (strb.issue ? ctlAddr[CMD_W-1:0] : '0) : seqCmd;
  assign brAdValid = strb.outOwn ? strb.issue : seqAdValid;

  // inbound direction
  assign bufFull   = (bufCount == FULL_LVL);
  assign bufEmpty  = (bufCount == '0);
  assign push      = strb.inOwn && brInValid && !bufFull;
  assign pop       = strb.bufPop && !bufEmpty;
  assign brInReady = strb.inOwn ? !bufFull : retReady;
  assign retData   = strb.inOwn ? (strb.retPush ? ctlWData : '0) : brIn;
  assign retEnq    = strb.inOwn ? (strb.retPush && retReady) : (brInValid && retReady);

  always_ff @(posedge clk) begin
    if (push) bufMem[wrPtr] <= brIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      bufCount <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   bufCount <= bufCount + 1'b1;
        2'b01:   bufCount <= bufCount - 1'b1;
        default: bufCount <= bufCount;
      endcase
    end
  end

  // side-effect-free read port
  assign statusWord = {seqBusy, strb.inOwn, strb.outOwn, bufCount, retCount, cmdQCount};

  always_comb begin
    case (ctlAddr)
      RD_STATUS:   ctlRdData = DATA_W'(statusWord);
      RD_CMD_HEAD: ctlRdData = cmdQData;
      RD_BUF_HEAD: ctlRdData = bufEmpty ? '0 : bufMem[rdPtr];
      default:     ctlRdData = '0;
    endcase
  end

  assert_buf_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    bufCount <= FULL_LVL);
  assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> (bufCount == $past(bufCount) + 1'b1));
  assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bufPop && !bufEmpty && !push) |=> (bufCount == $past(bufCount) - 1'b1));
  assert_no_ret_leak_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inOwn && retEnq) |-> strb.retPush);
endmodule

// File: rtl/bridge_takeover.sv
module bridge_takeover
  import bt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 5,
  parameter int BUF_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-1:0]     cmdQData,
  input  logic                  cmdQValid,
  output logic                  cmdQDeq,
  input  logic [CNT_W-1:0]      cmdQCount,
  output logic [DATA_W-1:0]     seqData,
  output logic                  seqValid,
  input  logic                  seqDeq,
  input  logic [DATA_W-1:0]     seqAd,
  input  logic [CMD_W-1:0]      seqCmd,
  input  logic                  seqAdValid,
  input  logic                  seqBusy,
  output logic [DATA_W-1:0]     brAd,
  output logic [CMD_W-1:0]      brCmd,
  output logic                  brAdValid,
  input  logic [DATA_W-1:0]     brIn,
  input  logic                  brInValid,
  output logic                  brInReady,
  output logic [DATA_W-1:0]     retData,
  output logic                  retEnq,
  input  logic                  retReady,
  input  logic [CNT_W-1:0]      retCount,
  input  logic [CTL_ADDR_W-1:0] ctlAddr,
  input  logic                  ctlWr,
  input  logic [DATA_W-1:0]     ctlWData,
  output logic [DATA_W-1:0]     ctlRdData
);
  strobes_t strb;
  logic     bufEmpty;

  bt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlAddr(ctlAddr),
    .modeBits(ctlWData[1:0]), .seqBusy(seqBusy), .brInValid(brInValid),
    .bufEmpty(bufEmpty), .strb(strb)
  );

  bt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctlAddr(ctlAddr), .ctlWData(ctlWData),
    .ctlRdData(ctlRdData), .cmdQData(cmdQData), .cmdQValid(cmdQValid),
    .cmdQDeq(cmdQDeq), .cmdQCount(cmdQCount), .seqData(seqData), .seqValid(seqValid),
    .seqDeq(seqDeq), .seqAd(seqAd), .seqCmd(seqCmd), .seqAdValid(seqAdValid),
    .seqBusy(seqBusy), .brAd(brAd), .brCmd(brCmd), .brAdValid(brAdValid),
    .brIn(brIn), .brInValid(brInValid), .brInReady(brInReady), .retData(retData),
    .retEnq(retEnq), .retReady(retReady), .retCount(retCount), .bufEmpty(bufEmpty)
  );
endmodule

// File: tb/sim_bridge_takeover.sv
`timescale 1ns/1ps
module sim_bridge_takeover;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cmdQData = '0, seqAd = '0, brIn = '0, ctlWData = '0;
  logic cmdQValid = 0, seqDeq = 0, seqAdValid = 0, seqBusy = 0;
  logic brInValid = 0, retReady = 0, ctlWr = 0;
  logic [4:0] cmdQCount = '0, retCount = '0;
  logic [1:0] seqCmd = '0;
  logic [3:0] ctlAddr = '0;
  logic [31:0] seqData, brAd, retData, ctlRdData;
  logic [1:0] brCmd;
  logic cmdQDeq, seqValid, brAdValid, brInReady, retEnq;

  always #4 clk = ~clk;  // 125 MHz

  bridge_takeover u0 (.*);

  int checks = 0, fails = 0;
  string ph = "R1";
  bit outMode = 0, inMode = 0, outReq = 0, inReq = 0;
  logic [31:0] bufQ[$];

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", what, ph, act, exp);
    end
  endtask

  task automatic compare();
    bit issue, pushW;
    logic [31:0] st, rd;
    issue = outMode && ctlWr && (ctlAddr[3:2] == 2'd1);
    pushW = inMode && ctlWr && (ctlAddr == 4'd10);
    chk("seqData R2", seqData, cmdQData);
    chk("seqValid R2 R5", {31'd0, seqValid}, {31'd0, outMode ? 1'b0 : cmdQValid});
    chk("cmdQDeq R2 R6", {31'd0, cmdQDeq},
        {31'd0, outMode ? (ctlWr && ctlAddr == 4'd8 && cmdQValid) : seqDeq});
    chk("brAd R2 R5", brAd, outMode ? (issue ? ctlWData : 32'd0) : seqAd);
    chk("brCmd R2 R5", {30'd0, brCmd}, {30'd0, outMode ? (issue ? ctlAddr[1:0] : 2'd0) : seqCmd});
    chk("brAdValid R2 R5", {31'd0, brAdValid}, {31'd0, outMode ? issue : seqAdValid});
    chk("brInReady R2 R7", {31'd0, brInReady}, {31'd0, inMode ? (bufQ.size() < 2) : retReady});
    chk("retData R2 R9", retData, inMode ? (pushW ? ctlWData : 32'd0) : brIn);
    chk("retEnq R2 R9", {31'd0, retEnq},
        {31'd0, inMode ? (pushW && retReady) : (brInValid && retReady)});
    st = {17'd0, seqBusy, inMode, outMode, 2'(bufQ.size()), retCount, cmdQCount};
    case (ctlAddr)
      4'd0: rd = st;
      4'd1: rd = cmdQData;
      4'd2: rd = (bufQ.size() != 0) ? bufQ[0] : 32'd0;
      default: rd = 32'd0;
    endcase
    chk("ctlRdData R8 R10", ctlRdData, rd);
  endtask

  task automatic update();
    bit modeWr, nOut, nIn, inIdle;
    int oldSize;
    if (!rstN) begin
      outMode = 0; inMode = 0; outReq = 0; inReq = 0; bufQ.delete();
      return;
    end
    modeWr  = ctlWr && ctlAddr == 4'd0;
    nOut    = modeWr ? ctlWData[0] : outReq;
    nIn     = modeWr ? ctlWData[1] : inReq;
    oldSize = bufQ.size();
    inIdle  = !brInValid && oldSize == 0;
    if (inMode && ctlWr && ctlAddr == 4'd9 && oldSize > 0) void'(bufQ.pop_front());
    if (inMode && brInValid && oldSize < 2) bufQ.push_back(brIn);
    if (!seqBusy) outMode = nOut;
    if (inIdle) inMode = nIn;
    outReq = nOut; inReq = nIn;
  endtask

  task automatic tick();
    #2;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic randIn(bit allowMode);
    cmdQData = $urandom; seqAd = $urandom; brIn = $urandom; ctlWData = $urandom;
    cmdQValid = 1'($urandom); seqDeq = 1'($urandom); seqAdValid = 1'($urandom);
    seqBusy = 1'($urandom); brInValid = 1'($urandom); retReady = 1'($urandom);
    cmdQCount = 5'($urandom); retCount = 5'($urandom); seqCmd = 2'($urandom);
    ctlWr = 1'($urandom);
    ctlAddr = 4'($urandom);
    if (ctlAddr == 4'd0 && !allowMode && ctlWr) ctlAddr = 4'd8;
    if (allowMode && ctlAddr == 4'd0 && ($urandom % 4) != 0) ctlWr = 1'b0;
  endtask

  task automatic quiet();
    ctlWr = 0; ctlAddr = 4'd0; brInValid = 0; seqBusy = 0; ctlWData = '0;
  endtask

  task automatic modeWrite(bit o, bit i);
    ctlWr = 1; ctlAddr = 4'd0; ctlWData = {30'd0, i, o};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(posedge clk); @(negedge clk);
    ph = "R1";
    cmdQCount = 5'd3; retCount = 5'd7;
    tick(); tick();
    rstN = 1'b1;
    tick(); tick();

    ph = "R2 R3";
    repeat (30) begin randIn(0); tick(); end

    ph = "R4";
    quiet(); seqBusy = 1; modeWrite(1, 0); tick();
    ctlWr = 0;
    repeat (3) tick();
    seqBusy = 0; tick();
    tick();

    ph = "R5 R6";
    repeat (25) begin randIn(0); tick(); end
    quiet(); cmdQValid = 0; ctlWr = 1; ctlAddr = 4'd8; tick();
    cmdQValid = 1; tick();
    ctlAddr = 4'd7; ctlWData = 32'hCAFE_0007; tick();
    ctlAddr = 4'd1; ctlWr = 0; tick();

    ph = "R4";
    quiet(); brInValid = 1; modeWrite(1, 1); tick();
    ctlWr = 0; tick();
    brInValid = 0; tick();
    tick();

    ph = "R7 R8 R9";
    quiet(); ctlAddr = 4'd2;
    brInValid = 1; brIn = 32'hA1; tick();
    brIn = 32'hB2; tick();
    brIn = 32'hC3; tick();
    tick();
    brInValid = 0; tick();
    ctlWr = 1; ctlAddr = 4'd9; tick();
    ctlAddr = 4'd9; tick();
    ctlAddr = 4'd9; tick();
    retReady = 1; ctlAddr = 4'd10; ctlWData = 32'h5555; tick();
    retReady = 0; tick();
    ctlWr = 0; ctlAddr = 4'd2; tick();
    repeat (40) begin randIn(0); tick(); end

    ph = "R4";
    quiet(); brInValid = 1; brIn = 32'hD4; tick();
    brInValid = 0; modeWrite(0, 0); tick();
    ctlWr = 0; tick(); tick();
    ctlWr = 1; ctlAddr = 4'd9; repeat (3) tick();
    ctlWr = 0; ctlAddr = 4'd0; tick(); tick();

    ph = "R4 R10";
    repeat (300) begin randIn(1); tick(); end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule